// File: doc/BRIEF.md
# Shift and Extension Replay Checker

This block sits beside an ALU and checks the result of every shift and every byte or halfword extension the ALU produces. For each check it takes the operand, the shift amount, an operation code and the result the ALU actually produced. It rebuilds the expected value on a single datapath: a right shifter that can fill with the sign bit, followed by an extender.

A left shift is not recomputed. The observed result is shifted back to the right and compared with the operand bits that survive the shift. The bits the shift vacated at the bottom of the result must be zero. Extensions use the same right shifter before the extender. With an amount of zero the check is a plain extension. With a byte-multiple amount it checks the realignment of a sub-word load, so that a byte or halfword taken from any lane of a word is verified.

A mismatch is reported as a single-cycle error pulse. The pulse appears in the cycle after the check was presented.

Top module: `shext_replay_chk`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `err` is low.
- R2: Operation code 1 (logical right shift) flags an error unless `observed` equals `operand_a` shifted right by `shamt` with zero fill. `shamt` ranges over 0 to 31.
- R3: Operation code 2 (arithmetic right shift) flags an error unless `observed` equals `operand_a` shifted right by `shamt`, with the vacated upper bits copied from bit 31 of `operand_a`.
- R4: Operation code 0 (left shift) shifts `observed` right by `shamt` and compares it with `operand_a`. Only the low 32−`shamt` bits of `operand_a` take part in the comparison, so an amount of 0 compares all 32 bits. Any difference flags an error.
- R5: For operation code 0, an error is also flagged if any of the low `shamt` bits of `observed` is set.
- R6: Operation codes 3 to 6 first shift `operand_a` right by `shamt` with zero fill, then extend the result. Code 3 sign-extends from bit 7, code 4 sign-extends from bit 15, code 5 zero-extends from bit 7 and code 6 zero-extends from bit 15. An error is flagged when `observed` differs from that value. An amount of 0 checks a plain extension, and amounts of 8, 16 or 24 check the realignment of a sub-word load.
- R7: `err` is a registered flag. It is high in a cycle only if `chk_valid` was high in the previous cycle and that check found a mismatch. Inputs presented while `chk_valid` is low never raise it.
- R8: Operation code 7 is reserved and never raises `err`, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_valid | input | 1 | The inputs of this cycle form a check |
| op | input | 3 | Operation code (0 left, 1 logical right, 2 arithmetic right, 3/4 sign-extend byte/half, 5/6 zero-extend byte/half, 7 reserved) |
| shamt | input | 5 | Shift amount, or right realignment amount for extensions |
| operand_a | input | 32 | Operand given to the ALU |
| observed | input | 32 | Result the ALU produced |
| err | output | 1 | Mismatch found by the check of the previous cycle |

## Verification
The error flag of one check is visible in the same cycle the next check is presented, so two results share a cycle. The bench provokes this with back-to-back valid cycles that alternate a bad left shift and a good extension. It confirms that each cycle's flag follows its own predecessor and not the inputs present alongside it. The two left-shift conditions can also fire together within one check. A vector that corrupts a surviving bit and a vacated bit at the same time must still give one pulse.

// File: rtl/shext_replay_chk.sv
module shext_replay_chk #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_valid,
  input  logic [2:0]    op,
  input  logic [SW-1:0] shamt,
  input  logic [W-1:0]  operand_a,
  input  logic [W-1:0]  observed,
  output logic          err
);
  localparam logic [2:0] OP_SLL   = 3'd0;
  localparam logic [2:0] OP_SRL   = 3'd1;
  localparam logic [2:0] OP_SRA   = 3'd2;
  localparam logic [2:0] OP_SEXTB = 3'd3;
  localparam logic [2:0] OP_SEXTH = 3'd4;
  localparam logic [2:0] OP_ZEXTB = 3'd5;
  localparam logic [2:0] OP_ZEXTH = 3'd6;
  localparam logic [W-1:0] ONES   = '1;

  logic [W-1:0] sh_in, shifted, keep_mask, vacated, replay;
  logic         fill, mismatch;

  assign sh_in     = (op == OP_SLL) ? observed : operand_a;
  assign fill      = (op == OP_SRA) & operand_a[W-1];
  assign shifted   = fill ? ~((~sh_in) >> shamt) : (sh_in >> shamt);
  assign keep_mask = ONES >> shamt;
  assign vacated   = observed & ~(ONES << shamt);

  always_comb begin
    case (op)
      OP_SEXTB: replay = {{(W-8){shifted[7]}},   shifted[7:0]};
      OP_SEXTH: replay = {{(W-16){shifted[15]}}, shifted[15:0]};
      OP_ZEXTB: replay = {{(W-8){1'b0}},         shifted[7:0]};
      OP_ZEXTH: replay = {{(W-16){1'b0}},        shifted[15:0]};
      default:  replay = shifted;
    endcase
  end

  always_comb begin
    case (op)
      OP_SLL:  mismatch = (((shifted ^ operand_a) & keep_mask) != '0) || (vacated != '0);
      OP_SRL, OP_SRA, OP_SEXTB, OP_SEXTH, OP_ZEXTB, OP_ZEXTH:
               mismatch = (replay != observed);
      default: mismatch = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= chk_valid & mismatch;
  end
endmodule

// File: rtl/shext_replay_chk_sva.sv
module shext_replay_chk_sva #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_valid,
  input logic [2:0]    op,
  input logic [SW-1:0] shamt,
  input logic [W-1:0]  operand_a,
  input logic [W-1:0]  observed,
  input logic          err
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !err);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !err);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && op == 3'd7) |=> !err);

  p_sll_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && op == 3'd0 && shamt == '0 && observed == operand_a) |=> !err);

  p_sll_low_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && op == 3'd0 && shamt != '0 && observed[0]) |=> err);

  p_srl_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && op == 3'd1 && observed == (operand_a >> shamt)) |=> !err);
endmodule

bind shext_replay_chk shext_replay_chk_sva #(.W(W), .SW(SW)) i_sva (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .op(op), .shamt(shamt),
  .operand_a(operand_a), .observed(observed), .err(err)
);

// File: tb/test_shext_replay_chk.sv
module test_shext_replay_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [4:0]  shamt = 5'd0;
  logic [31:0] operand_a = '0;
  logic [31:0] observed = '0;
  logic        err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shext_replay_chk i_shext_replay_chk (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .op(op), .shamt(shamt),
    .operand_a(operand_a), .observed(observed), .err(err)
  );

  localparam int NV = 20;
  // {op, shamt, operand_a, observed, expected err}
  localparam logic [72:0] VEC [NV] = '{
    {3'd1, 5'd4,  32'hF00000F0, 32'h0F00000F, 1'b0},  // R2
    {3'd1, 5'd4,  32'hF00000F0, 32'h0F00001F, 1'b1},  // R2
    {3'd2, 5'd4,  32'hF00000F0, 32'hFF00000F, 1'b0},  // R3
    {3'd2, 5'd4,  32'hF00000F0, 32'h0F00000F, 1'b1},  // R3
    {3'd2, 5'd31, 32'h80000000, 32'hFFFFFFFF, 1'b0},  // R3
    {3'd0, 5'd8,  32'h12345678, 32'h34567800, 1'b0},  // R4
    {3'd0, 5'd8,  32'h12345678, 32'h34567900, 1'b1},  // R4
    {3'd0, 5'd8,  32'h12345678, 32'h34567801, 1'b1},  // R5
    {3'd0, 5'd8,  32'h12345678, 32'h34567980, 1'b1},  // R4 and R5 together
    {3'd0, 5'd0,  32'hDEADBEEF, 32'hDEADBEEF, 1'b0},  // R4
    {3'd0, 5'd0,  32'hDEADBEEF, 32'h5EADBEEF, 1'b1},  // R4
    {3'd0, 5'd31, 32'h00000003, 32'h80000000, 1'b0},  // R4
    {3'd3, 5'd0,  32'h00000080, 32'hFFFFFF80, 1'b0},  // R6
    {3'd3, 5'd0,  32'h00000080, 32'h00000080, 1'b1},  // R6
    {3'd4, 5'd0,  32'h12348001, 32'hFFFF8001, 1'b0},  // R6
    {3'd5, 5'd16, 32'hAABBCCDD, 32'h000000BB, 1'b0},  // R6
    {3'd6, 5'd16, 32'hAABBCCDD, 32'h0000AABB, 1'b0},  // R6
    {3'd3, 5'd24, 32'hAABBCCDD, 32'hFFFFFFAA, 1'b0},  // R6
    {3'd6, 5'd0,  32'hAABBCCDD, 32'hFFFFCCDD, 1'b1},  // R6
    {3'd7, 5'd3,  32'h00000000, 32'hFFFFFFFF, 1'b0}   // R8
  };

  task automatic check(input logic exp, input string req);
    n_run++;
    if (err !== exp) begin
      n_fail++;
      $display("FAIL %s: err=%0b expected %0b", req, err, exp);
    end
  endtask

  task automatic present(input logic v, input logic [2:0] o, input logic [4:0] s,
                         input logic [31:0] a, input logic [31:0] obs);
    chk_valid = v; op = o; shamt = s; operand_a = a; observed = obs;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      present(1'b1, VEC[i][72:70], VEC[i][69:65], VEC[i][64:33], VEC[i][32:1]);
      @(negedge clk);
      present(1'b0, 3'd0, 5'd0, 32'h0, 32'h0);
      check(VEC[i][0], $sformatf("R2-R8 vector %0d", i));
    end

    // R7: mismatching data with chk_valid low
    present(1'b0, 3'd1, 5'd1, 32'hFFFFFFFF, 32'h0);
    @(negedge clk);
    check(1'b0, "R7 invalid input ignored");

    // R7: back-to-back, bad SLL then good extension then idle
    present(1'b1, 3'd0, 5'd4, 32'h0000000F, 32'h000000F1);
    @(negedge clk);
    present(1'b1, 3'd5, 5'd0, 32'h12345678, 32'h00000078);
    check(1'b1, "R7 first of pair");
    @(negedge clk);
    present(1'b1, 3'd2, 5'd1, 32'h80000000, 32'h40000000);
    check(1'b0, "R7 second of pair");
    @(negedge clk);
    present(1'b0, 3'd0, 5'd0, 32'h0, 32'h0);
    check(1'b1, "R3 third of chain");
    @(negedge clk);
    check(1'b0, "R7 pulse lasts one cycle");

    // R1: reset clears a pending pulse
    present(1'b1, 3'd1, 5'd0, 32'h1, 32'h2);
    @(negedge clk);
    present(1'b0, 3'd0, 5'd0, 32'h0, 32'h0);
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule